// File: doc/BRIEF.md
# USB Inter-Packet Gap Timer

This block sits beside a low-speed or full-speed USB host transmitter and governs the idle time between packets. It watches the decoded bus state and a strobe that ticks twice per bit time. When an EOP ends (the bus moves from SE0 to J), it starts counting half-bit units. The count stops when the next packet begins (J to K). All timing is in half bits, so the 6.5 and 7.5 bit-time limits become the whole counts 13 and 15.

A transmit request is held until the bus has been idle long enough, and is then launched with a one-cycle start pulse. The minimum idle time is two bit times. A nonzero gap setting asks for a longer, fixed spacing, which is used for back-to-back packets of one transaction. That spacing never exceeds the host's 7.5 bit-time response limit.

When the host expects an answer, the block arms a response watchdog at the end of its EOP. If the device has not started its packet within the allowed window, a timeout pulse is raised. The window depends on whether the device has a detachable or a captive cable. When no answer is expected, no upper limit applies.

Top module: `usb_ipg_timer`

## Requirements
- R1: `line_state` is encoded 00 = SE0, 01 = J, 10 = K, 11 = SE1. A clock in which the previous sample was SE0 and the current one is J marks the end of an EOP. `gap_count` is 0 after that edge and then rises by one on each `half_bit_strobe`. It saturates at all ones (63 with the default 6-bit width).
- R2: A J-to-K transition clears `gap_count` to 0 and ends the idle period. Strobes are not counted again until the next EOP end.
- R3: `tx_start` never fires before 4 half bits of idle. With `gap_cfg` of 0 or 1, a pending request launches on the 4th strobe after the EOP end. `tx_start` is high for exactly the one cycle after that strobe.
- R4: With `gap_cfg` from 2 to 7, a pending request launches on strobe number 2 x `gap_cfg` after the EOP end.
- R5: With `gap_cfg` of 8 or more, the launch point is clamped to strobe 15, the 7.5 bit-time host limit.
- R6: A request that arrives after the launch point has passed is granted on the next strobe.
- R7: A request made during a packet, or before the launch point, is held and never dropped. Each request gives exactly one `tx_start`.
- R8: If `expect_resp` is high on the EOP-end clock, the response watchdog is armed. It raises `resp_timeout` for one cycle after strobe 14 when `captive_sel` = 0, or after strobe 16 when `captive_sel` = 1, unless the device has started its packet first.
- R9: If `expect_resp` is low on the EOP-end clock, `resp_timeout` stays low however long the bus idles.
- R10: A J-to-K transition while the watchdog is armed disarms it. No timeout follows, even if the strobes continue for longer than the window.
- R11: While synchronous reset `rst` is high, and on the clock after it is released, `tx_start` and `resp_timeout` are 0 and `gap_count` reads all ones (long idle). No request is pending. A request made after reset therefore launches on the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_state | input | 2 | Decoded bus state: 00 SE0, 01 J, 10 K, 11 SE1 |
| half_bit_strobe | input | 1 | One-cycle pulse at twice the bit rate |
| tx_req | input | 1 | Pulse requesting the next packet launch |
| expect_resp | input | 1 | Arm the response watchdog at the coming EOP end |
| captive_sel | input | 1 | 1 selects the 7.5 bit window, 0 the 6.5 bit window |
| gap_cfg | input | 4 | Fixed launch gap in bit times; 0 or 1 means the minimum |
| tx_start | output | 1 | One-cycle launch pulse for the transmitter |
| resp_timeout | output | 1 | One-cycle pulse when a device response is late |
| gap_count | output | 6 | Half bits of idle since the last EOP end |

## Verification
The bench sweeps every `gap_cfg` value and counts the strobes until launch. A wrong doubling or a missing clamp would launch at the wrong strobe, and a threshold off by one would launch a half bit early. For both cable types it places the device's start of packet exactly on the last legal strobe, and also lets the window expire. A limit off by one would either flag a response that was on time or miss a late one. Requests made during a packet or after the launch point are checked to give exactly one start pulse. A block that dropped a held request, or that counted while a packet was on the bus, would show no pulse or an early one.

// File: rtl/usb_ipg_pkg.sv
package usb_ipg_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    localparam int unsigned MIN_HALF_BITS   = 4;
    localparam int unsigned HOST_LIMIT_HALF = 15;
    localparam int unsigned DET_LIMIT_HALF  = 13;
    localparam int unsigned CAPT_LIMIT_HALF = 15;

endpackage

// File: rtl/usb_ipg_line_mon.sv
module usb_ipg_line_mon
    import usb_ipg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_state,
    output logic       eop_end,
    output logic       sop
);

    typedef struct packed {
        line_t prev;
    } mon_t;

    mon_t  mon_d, mon_q;
    line_t cur;

    always_comb begin
        cur      = line_t'(line_state);
        mon_d    = mon_q;
        mon_d.prev = cur;
        eop_end  = (mon_q.prev == LS_SE0) && (cur == LS_J);
        sop      = (mon_q.prev == LS_J) && (cur == LS_K);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_q.prev <= LS_J;
        end else begin
            mon_q <= mon_d;
        end
    end

endmodule

// File: rtl/usb_ipg_gap_ctr.sv
module usb_ipg_gap_ctr #(
    parameter int unsigned GAP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             eop_end,
    input  logic             sop,
    output logic [GAP_W-1:0] cnt,
    output logic [GAP_W-1:0] next_cnt,
    output logic             tick
);

    localparam logic [GAP_W-1:0] CNT_MAX = {GAP_W{1'b1}};

    typedef struct packed {
        logic [GAP_W-1:0] cnt;
        logic             idle;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d    = ctr_q;
        next_cnt = (ctr_q.cnt == CNT_MAX) ? CNT_MAX : ctr_q.cnt + 1'b1;
        tick     = strobe && ctr_q.idle && !sop && !eop_end;
        if (eop_end) begin
            ctr_d.cnt  = '0;
            ctr_d.idle = 1'b1;
        end else if (sop) begin
            ctr_d.cnt  = '0;
            ctr_d.idle = 1'b0;
        end else if (tick) begin
            ctr_d.cnt  = next_cnt;
        end
        cnt = ctr_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q.cnt  <= CNT_MAX;
            ctr_q.idle <= 1'b1;
        end else begin
            ctr_q <= ctr_d;
        end
    end

endmodule

// File: rtl/usb_ipg_tx_gate.sv
module usb_ipg_tx_gate
    import usb_ipg_pkg::*;
#(
    parameter int unsigned GAP_W = 6,
    parameter int unsigned CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_req,
    input  logic [CFG_W-1:0] gap_cfg,
    input  logic             tick,
    input  logic [GAP_W-1:0] next_cnt,
    output logic             tx_start
);

    localparam logic [GAP_W-1:0] MIN_T = GAP_W'(MIN_HALF_BITS);
    localparam logic [GAP_W-1:0] MAX_T = GAP_W'(HOST_LIMIT_HALF);

    typedef struct packed {
        logic pend;
        logic start;
    } gate_t;

    gate_t            gate_d, gate_q;
    logic [GAP_W-1:0] twice;
    logic [GAP_W-1:0] thresh;
    logic             req_pend;
    logic             grant;

    always_comb begin
        twice = GAP_W'({gap_cfg, 1'b0});
        if (twice < MIN_T) begin
            thresh = MIN_T;
        end else if (twice > MAX_T) begin
            thresh = MAX_T;
        end else begin
            thresh = twice;
        end
        req_pend     = gate_q.pend || tx_req;
        grant        = req_pend && tick && (next_cnt >= thresh);
        gate_d.pend  = req_pend && !grant;
        gate_d.start = grant;
        tx_start     = gate_q.start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

endmodule

// File: rtl/usb_ipg_resp_wd.sv
module usb_ipg_resp_wd
    import usb_ipg_pkg::*;
#(
    parameter int unsigned GAP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expect_resp,
    input  logic             captive_sel,
    input  logic             eop_end,
    input  logic             sop,
    input  logic             tick,
    input  logic [GAP_W-1:0] next_cnt,
    output logic             resp_timeout
);

    localparam logic [GAP_W-1:0] LIM_DET  = GAP_W'(DET_LIMIT_HALF);
    localparam logic [GAP_W-1:0] LIM_CAPT = GAP_W'(CAPT_LIMIT_HALF);

    typedef struct packed {
        logic armed;
        logic fired;
    } wd_t;

    wd_t              wd_d, wd_q;
    logic [GAP_W-1:0] limit;
    logic             late;

    always_comb begin
        limit = captive_sel ? LIM_CAPT : LIM_DET;
        late  = wd_q.armed && tick && (next_cnt > limit);
        wd_d  = wd_q;
        if (eop_end) begin
            wd_d.armed = expect_resp;
        end else if (sop || late) begin
            wd_d.armed = 1'b0;
        end
        wd_d.fired   = late;
        resp_timeout = wd_q.fired;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

endmodule

// File: rtl/usb_ipg_timer.sv
module usb_ipg_timer #(
    parameter int unsigned GAP_W = 6,
    parameter int unsigned CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       line_state,
    input  logic             half_bit_strobe,
    input  logic             tx_req,
    input  logic             expect_resp,
    input  logic             captive_sel,
    input  logic [CFG_W-1:0] gap_cfg,
    output logic             tx_start,
    output logic             resp_timeout,
    output logic [GAP_W-1:0] gap_count
);

    logic             eop_end;
    logic             sop;
    logic             tick;
    logic [GAP_W-1:0] next_cnt;

    usb_ipg_line_mon u_line (
        .clk        (clk),
        .rst        (rst),
        .line_state (line_state),
        .eop_end    (eop_end),
        .sop        (sop)
    );

    usb_ipg_gap_ctr #(.GAP_W(GAP_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .strobe   (half_bit_strobe),
        .eop_end  (eop_end),
        .sop      (sop),
        .cnt      (gap_count),
        .next_cnt (next_cnt),
        .tick     (tick)
    );

    usb_ipg_tx_gate #(.GAP_W(GAP_W), .CFG_W(CFG_W)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .tx_req   (tx_req),
        .gap_cfg  (gap_cfg),
        .tick     (tick),
        .next_cnt (next_cnt),
        .tx_start (tx_start)
    );

    usb_ipg_resp_wd #(.GAP_W(GAP_W)) u_wd (
        .clk          (clk),
        .rst          (rst),
        .expect_resp  (expect_resp),
        .captive_sel  (captive_sel),
        .eop_end      (eop_end),
        .sop          (sop),
        .tick         (tick),
        .next_cnt     (next_cnt),
        .resp_timeout (resp_timeout)
    );

endmodule

// File: rtl/usb_ipg_checker.sv
module usb_ipg_checker #(
    parameter int unsigned GAP_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       line_state,
    input logic             tx_start,
    input logic             resp_timeout,
    input logic [GAP_W-1:0] gap_count
);

    // R3: a launch only ever follows at least four idle half bits
    a_r3_min_gap: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (gap_count >= GAP_W'(4)));

    // R8: a timeout only appears once the shorter window is exceeded
    a_r8_late_only: assert property (@(posedge clk) disable iff (rst)
        resp_timeout |-> (gap_count >= GAP_W'(14)));

    // R1: EOP end restarts the count
    a_r1_eop_restart: assert property (@(posedge clk) disable iff (rst)
        ($past(line_state) == 2'b00 && line_state == 2'b01) |=> (gap_count == '0));

    // R10: start of packet suppresses a timeout on the next cycle
    a_r10_sop_disarm: assert property (@(posedge clk) disable iff (rst)
        ($past(line_state) == 2'b01 && line_state == 2'b10) |=> !resp_timeout);

    // R11: outputs idle right after reset
    a_r11_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!tx_start && !resp_timeout && gap_count == {GAP_W{1'b1}}));

endmodule

bind usb_ipg_timer usb_ipg_checker #(.GAP_W(GAP_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .line_state   (line_state),
    .tx_start     (tx_start),
    .resp_timeout (resp_timeout),
    .gap_count    (gap_count)
);

// File: tb/usb_ipg_timer_tb.sv
`timescale 1ns/1ps
module usb_ipg_timer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] line_state;
    logic       half_bit_strobe;
    logic       tx_req;
    logic       expect_resp;
    logic       captive_sel;
    logic [3:0] gap_cfg;
    logic       tx_start;
    logic       resp_timeout;
    logic [5:0] gap_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10;

    always #2.5 clk = ~clk;

    usb_ipg_timer u_dut (
        .clk             (clk),
        .rst             (rst),
        .line_state      (line_state),
        .half_bit_strobe (half_bit_strobe),
        .tx_req          (tx_req),
        .expect_resp     (expect_resp),
        .captive_sel     (captive_sel),
        .gap_cfg         (gap_cfg),
        .tx_start        (tx_start),
        .resp_timeout    (resp_timeout),
        .gap_count       (gap_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one clock; outputs are read 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe_once();
        half_bit_strobe = 1'b1;
        step();
        half_bit_strobe = 1'b0;
        step();
    endtask

    task automatic eop();
        line_state = SE0;
        step();
        line_state = LJ;
        step();
    endtask

    task automatic pulse_req();
        tx_req = 1'b1;
        step();
        tx_req = 1'b0;
    endtask

    initial begin
        int exp_at;
        int starts;
        rst = 1'b1; line_state = LJ; half_bit_strobe = 1'b0; tx_req = 1'b0;
        expect_resp = 1'b0; captive_sel = 1'b0; gap_cfg = 4'd0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R11 tx_start after reset", tx_start, 0);
        chk("R11 resp_timeout after reset", resp_timeout, 0);
        chk("R11 gap_count after reset", gap_count, 63);

        // R11: long idle after reset, first strobe grants
        pulse_req();
        half_bit_strobe = 1'b1;
        step();
        half_bit_strobe = 1'b0;
        chk("R11 launch on first strobe", tx_start, 1);
        step();
        chk("R3 start is one cycle", tx_start, 0);

        // R3 R4 R5: sweep every gap setting
        for (int cfg = 0; cfg < 16; cfg++) begin
            gap_cfg = 4'(cfg);
            exp_at = (2 * cfg < 4) ? 4 : ((2 * cfg > 15) ? 15 : 2 * cfg);
            eop();
            chk("R1 count zero after EOP end", gap_count, 0);
            pulse_req();
            for (int k = 1; k <= 17; k++) begin
                half_bit_strobe = 1'b1;
                step();
                half_bit_strobe = 1'b0;
                chk(cfg < 2 ? "R3 launch strobe" : (cfg < 8 ? "R4 launch strobe" : "R5 launch strobe"),
                    tx_start, (k == exp_at) ? 1 : 0);
                chk("R1 count per strobe", gap_count, k);
                step();
            end
        end

        // R1: saturation
        gap_cfg = 4'd0;
        eop();
        for (int k = 0; k < 70; k++) strobe_once();
        chk("R1 saturated count", gap_count, 63);

        // R6: late request granted on next strobe
        eop();
        for (int k = 0; k < 10; k++) strobe_once();
        pulse_req();
        half_bit_strobe = 1'b1;
        step();
        half_bit_strobe = 1'b0;
        chk("R6 late request launch", tx_start, 1);
        step();

        // R2 R7: request during a packet is held; count frozen at 0 during packet
        line_state = LK;
        step();
        chk("R2 J to K clears count", gap_count, 0);
        pulse_req();
        starts = 0;
        for (int k = 0; k < 6; k++) begin
            half_bit_strobe = 1'b1; step(); half_bit_strobe = 1'b0;
            starts += tx_start;
            step();
        end
        chk("R2 no counting during packet", gap_count, 0);
        chk("R7 no launch during packet", starts, 0);
        eop();
        exp_at = 0;
        for (int k = 1; k <= 10; k++) begin
            half_bit_strobe = 1'b1; step(); half_bit_strobe = 1'b0;
            starts += tx_start;
            if (tx_start && exp_at == 0) exp_at = k;
            step();
        end
        chk("R7 exactly one launch", starts, 1);
        chk("R7 held request launch strobe", exp_at, 4);

        // R8: window expiry for both cable types
        for (int c = 0; c < 2; c++) begin
            captive_sel = c[0];
            expect_resp = 1'b1;
            eop();
            expect_resp = 1'b0;
            for (int k = 1; k <= 20; k++) begin
                half_bit_strobe = 1'b1; step(); half_bit_strobe = 1'b0;
                chk("R8 timeout strobe", resp_timeout, (k == (c ? 16 : 14)) ? 1 : 0);
                step();
            end
        end

        // R10: device starts exactly at the last legal strobe
        for (int c = 0; c < 2; c++) begin
            captive_sel = c[0];
            expect_resp = 1'b1;
            eop();
            expect_resp = 1'b0;
            for (int k = 0; k < (c ? 15 : 13); k++) strobe_once();
            line_state = LK;
            half_bit_strobe = 1'b1;
            step();
            half_bit_strobe = 1'b0;
            starts = resp_timeout;
            step();
            line_state = LJ;
            for (int k = 0; k < 10; k++) begin
                half_bit_strobe = 1'b1; step(); half_bit_strobe = 1'b0;
                starts += resp_timeout;
                step();
            end
            chk("R10 no timeout after device start", starts, 0);
        end

        // R9: no response expected, no limit
        expect_resp = 1'b0;
        eop();
        starts = 0;
        for (int k = 0; k < 30; k++) begin
            half_bit_strobe = 1'b1; step(); half_bit_strobe = 1'b0;
            starts += resp_timeout;
            step();
        end
        chk("R9 unrelated gap never times out", starts, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule